// File: doc/BRIEF.md
# Rotating Register File with Base-Offset Renaming

This block is a multi-ported register file whose upper region is renamed through a moving base. Every logical specifier presented on a read or write port goes through the same mapping. Specifiers in the low, fixed region address storage directly. Specifiers in the upper, rotating region are offset by a base value, and the sum wraps within that region. The file has two combinational read ports and one synchronous write port.

A loop-closing branch pulses `loop_step`, which lowers the base by one. A value written under logical specifier k can then be read under specifier k+1 in the next iteration. A software-pipelined loop can therefore express a producer-to-consumer distance of d iterations as a specifier difference of d, and each iteration works on a fresh set of registers without duplicated code. A synchronous `base_clr` input returns the base to zero at loop entry.

Top module: `rot_regfile`

## Requirements
- R1: After reset every logical register reads zero on both ports, and the base is zero.
- R2: A logical specifier below NUM_FIXED (default 8) reaches the physical register of the same number, whatever the base.
- R3: A logical specifier l at or above NUM_FIXED reaches physical register NUM_FIXED + ((l - NUM_FIXED + base) mod ROT_SIZE), with ROT_SIZE a power of two (default 32, giving 40 registers in total).
- R4: A pulse on `loop_step` lowers the base by one, so a value written under rotating specifier k reads back under k+1 after one step. The top rotating specifier wraps onto the first one (39 moves to 8).
- R5: Stepping while the base is 0 sets it to ROT_SIZE-1.
- R6: `base_clr` sets the base to 0 at the next edge and takes priority over a `loop_step` in the same cycle.
- R7: Reads are combinational. A read that maps to the same physical register as a write in the same cycle returns the write data.
- R8: A write in the same cycle as a `loop_step` is placed using the base from before the step.
- R9: The two read ports select and return data independently of each other.
- R10: Contents of the fixed region survive any number of base steps and clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd0_lreg | input | 6 | Logical specifier, read port 0 |
| rd0_data | output | 32 | Read data, port 0 |
| rd1_lreg | input | 6 | Logical specifier, read port 1 |
| rd1_data | output | 32 | Read data, port 1 |
| wr_en | input | 1 | Write enable |
| wr_lreg | input | 6 | Logical specifier, write port |
| wr_data | input | 32 | Write data |
| loop_step | input | 1 | Loop-closing branch strobe, lowers the base |
| base_clr | input | 1 | Sets the base to zero |

## Verification
The bench uses the default parameters: 40 registers, 8 of them fixed and 32 rotating, with 32-bit data. A rotating region of only 32 entries lets the bench run 32 steps, a full base cycle, in a few dozen clocks. This reaches the wrap from 0 to 31, the wrap from the top specifier onto the first rotating one, and the return of the base to its starting value. The small fixed region lets the bench read every logical register after reset and confirm that fixed entries keep their values across many steps.

// File: rtl/rrf_pkg.sv
package rrf_pkg;

    typedef enum logic [1:0] {
        BASE_HOLD  = 2'd0,
        BASE_STEP  = 2'd1,
        BASE_CLEAR = 2'd2
    } base_op_e;

endpackage

// File: rtl/rrf_base_ctrl.sv
module rrf_base_ctrl
    import rrf_pkg::*;
#(
    parameter int ROT_SIZE = 32,
    localparam int RW = $clog2(ROT_SIZE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          loop_step,
    input  logic          base_clr,
    output logic [RW-1:0] base
);

    base_op_e op;

    always_comb begin
        if (base_clr)       op = BASE_CLEAR;
        else if (loop_step) op = BASE_STEP;
        else                op = BASE_HOLD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
        end else begin
            unique case (op)
                BASE_CLEAR: base <= '0;
                BASE_STEP:  base <= base - 1'b1;
                default:    base <= base;
            endcase
        end
    end

    assert_step_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_step && !base_clr && base != '0) |=> (base + 1'b1 == $past(base)));

    assert_step_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_step && !base_clr && base == '0) |=> (base == RW'(ROT_SIZE - 1)));

    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        base_clr |=> (base == '0));

    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_step && !base_clr) |=> $stable(base));

endmodule

// File: rtl/rrf_map.sv
module rrf_map #(
    parameter int NUM_REGS = 40,
    parameter int NUM_FIXED = 8,
    localparam int AW = $clog2(NUM_REGS),
    localparam int RW = $clog2(NUM_REGS - NUM_FIXED)
) (
    input  logic [AW-1:0] lreg,
    input  logic [RW-1:0] base,
    output logic [AW-1:0] phys
);

    logic [RW-1:0] offset;

    always_comb begin
        offset = RW'(lreg - AW'(NUM_FIXED)) + base;
        if (lreg < AW'(NUM_FIXED)) phys = lreg;
        else                       phys = AW'(NUM_FIXED) + AW'(offset);
    end

endmodule

// File: rtl/rrf_storage.sv
module rrf_storage #(
    parameter int NUM_REGS = 40,
    parameter int DATA_W = 32,
    parameter int NUM_RD = 2,
    localparam int AW = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_idx  [NUM_RD],
    output logic [DATA_W-1:0] rd_data [NUM_RD]
);

    logic [DATA_W-1:0] mem [NUM_REGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        always_comb begin
            if (wr_en && wr_idx == rd_idx[p]) rd_data[p] = wr_data;
            else                              rd_data[p] = mem[rd_idx[p]];
        end
    end

    assert_wr_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < AW'(NUM_REGS)));

    assert_wr_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/rot_regfile.sv
module rot_regfile #(
    parameter int NUM_REGS = 40,
    parameter int NUM_FIXED = 8,
    parameter int DATA_W = 32,
    localparam int ROT_SIZE = NUM_REGS - NUM_FIXED,
    localparam int AW = $clog2(NUM_REGS),
    localparam int RW = $clog2(ROT_SIZE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rd0_lreg,
    output logic [DATA_W-1:0] rd0_data,
    input  logic [AW-1:0]     rd1_lreg,
    output logic [DATA_W-1:0] rd1_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_lreg,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              loop_step,
    input  logic              base_clr
);

    localparam int NPORT = 3;

    logic [RW-1:0]     base;
    logic [AW-1:0]     lreg_v [NPORT];
    logic [AW-1:0]     phys_v [NPORT];
    logic [AW-1:0]     rd_idx [2];
    logic [DATA_W-1:0] rd_val [2];

    initial begin
        if ((1 << RW) != ROT_SIZE) $error("rotating region size must be a power of two");
    end

    rrf_base_ctrl #(.ROT_SIZE(ROT_SIZE)) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .loop_step (loop_step),
        .base_clr  (base_clr),
        .base      (base)
    );

    assign lreg_v[0] = rd0_lreg;
    assign lreg_v[1] = rd1_lreg;
    assign lreg_v[2] = wr_lreg;

    for (genvar g = 0; g < NPORT; g++) begin : g_map
        rrf_map #(.NUM_REGS(NUM_REGS), .NUM_FIXED(NUM_FIXED)) u_map (
            .lreg (lreg_v[g]),
            .base (base),
            .phys (phys_v[g])
        );
    end

    assign rd_idx[0] = phys_v[0];
    assign rd_idx[1] = phys_v[1];

    rrf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_RD(2)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (phys_v[2]),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_val)
    );

    assign rd0_data = rd_val[0];
    assign rd1_data = rd_val[1];

    assert_fixed_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_lreg < AW'(NUM_FIXED)) |-> (phys_v[0] == rd0_lreg));

    assert_rot_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1_lreg >= AW'(NUM_FIXED)) |-> (phys_v[1] >= AW'(NUM_FIXED)));

    assert_fwd_port0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_lreg == rd0_lreg) |-> (rd0_data == wr_data));

    assert_fwd_port1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_lreg == rd1_lreg) |-> (rd1_data == wr_data));

endmodule

// File: tb/sim_rot_regfile.sv
`timescale 1ns/1ps
module sim_rot_regfile;

    localparam int AW = 6;
    localparam int DW = 32;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] wl;
        logic [DW-1:0] wd;
        logic          br;
        logic          clr;
        logic [AW-1:0] r0;
        logic [DW-1:0] e0;
        logic [AW-1:0] r1;
        logic [DW-1:0] e1;
    } vec_t;

    localparam int NVEC = 7;
    // Base starts at 0. Expected values follow R3 mapping by hand.
    localparam vec_t TBL [NVEC] = '{
        '{1'b1, 6'd10, 32'hA1A1_0001, 1'b0, 1'b0, 6'd10, 32'hA1A1_0001, 6'd3,  32'h0},           // R7 forward, R9
        '{1'b1, 6'd3,  32'hB2B2_0002, 1'b1, 1'b0, 6'd10, 32'hA1A1_0001, 6'd11, 32'h0},           // step -> base 31
        '{1'b0, 6'd0,  32'h0,         1'b0, 1'b0, 6'd11, 32'hA1A1_0001, 6'd3,  32'hB2B2_0002},   // R4, R2
        '{1'b1, 6'd11, 32'hC3C3_0003, 1'b1, 1'b0, 6'd11, 32'hC3C3_0003, 6'd10, 32'h0},           // R8 write+step
        '{1'b0, 6'd0,  32'h0,         1'b0, 1'b0, 6'd12, 32'hC3C3_0003, 6'd11, 32'h0},           // R8 old base used
        '{1'b0, 6'd0,  32'h0,         1'b1, 1'b1, 6'd3,  32'hB2B2_0002, 6'd8,  32'h0},           // R6 clear wins
        '{1'b0, 6'd0,  32'h0,         1'b0, 1'b0, 6'd10, 32'hC3C3_0003, 6'd12, 32'h0}            // R6 base is 0
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] rd0_lreg = '0, rd1_lreg = '0, wr_lreg = '0;
    logic [DW-1:0] rd0_data, rd1_data, wr_data = '0;
    logic          wr_en = 1'b0, loop_step = 1'b0, base_clr = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rot_regfile u0 (
        .clk(clk), .rst_n(rst_n),
        .rd0_lreg(rd0_lreg), .rd0_data(rd0_data),
        .rd1_lreg(rd1_lreg), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_lreg(wr_lreg), .wr_data(wr_data),
        .loop_step(loop_step), .base_clr(base_clr)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic we, input logic [AW-1:0] wl, input logic [DW-1:0] wd,
                         input logic br, input logic clr,
                         input logic [AW-1:0] r0, input logic [AW-1:0] r1);
        wr_en = we; wr_lreg = wl; wr_data = wd;
        loop_step = br; base_clr = clr;
        rd0_lreg = r0; rd1_lreg = r1;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);
        tick();
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every logical register reads zero after reset
        for (int i = 0; i < 40; i++) begin
            drive(1'b0, '0, '0, 1'b0, 1'b0, AW'(i), AW'(39 - i));
            check("R1 port0", rd0_data, '0);
            check("R1 port1", rd1_data, '0);
        end

        // Table walk: R2 R4 R6 R7 R8 R9
        for (int v = 0; v < NVEC; v++) begin
            drive(TBL[v].we, TBL[v].wl, TBL[v].wd, TBL[v].br, TBL[v].clr, TBL[v].r0, TBL[v].r1);
            check($sformatf("R2/R4/R6/R7/R8/R9 vec%0d port0", v), rd0_data, TBL[v].e0);
            check($sformatf("R2/R4/R6/R7/R8/R9 vec%0d port1", v), rd1_data, TBL[v].e1);
            tick();
        end

        // R5 and R4 wrap: base 0, write logical 39 (phys 39), step -> base 31
        drive(1'b1, 6'd39, 32'hD4D4_0004, 1'b1, 1'b0, 6'd39, 6'd8);
        tick();
        drive(1'b0, '0, '0, 1'b0, 1'b0, 6'd8, 6'd39);
        check("R5 wrap logical 8 -> phys 39", rd0_data, 32'hD4D4_0004);
        check("R5 logical 39 -> phys 38", rd1_data, 32'h0);

        // R3: 31 more steps bring base back to 0
        for (int s = 0; s < 31; s++) begin
            drive(1'b0, '0, '0, 1'b1, 1'b0, 6'd3, 6'd10);
            tick();
        end
        drive(1'b0, '0, '0, 1'b0, 1'b0, 6'd10, 6'd39);
        check("R3 full cycle logical 10", rd0_data, 32'hC3C3_0003);
        check("R3 full cycle logical 39", rd1_data, 32'hD4D4_0004);
        drive(1'b0, '0, '0, 1'b0, 1'b0, 6'd3, 6'd9);
        check("R10 fixed survives steps", rd0_data, 32'hB2B2_0002);
        check("R3 untouched phys 9", rd1_data, 32'h0);

        // R1: reset again clears contents
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        drive(1'b0, '0, '0, 1'b0, 1'b0, 6'd3, 6'd10);
        check("R1 re-reset fixed", rd0_data, '0);
        check("R1 re-reset rotating", rd1_data, '0);

        finish_run();
    end

endmodule